// File: doc/BRIEF.md
# Banked Memory Map Decoder

This block sits between an 8-bit processor and the memories and peripherals it reaches over a 16-bit address bus. It holds two on-chip banking registers: a direction register at address 0 and a port register at address 1. From these it forms a 3-bit effective configuration. Each configuration bit is forced to 1 whenever its direction bit is 0, and takes the port bit otherwise. For every address the block decodes which one target is reached: main RAM, one of three ROM overlays, one of several peripheral windows inside the I/O page, an open (unpopulated) I/O area, or the banking registers themselves.

Alongside the one-hot target select, the block returns the local offset for the chosen ROM or peripheral. It also returns a read-data drive mask and a write routing. ROM overlays never take a write: any store to an overlaid address lands in the RAM underneath. Only a mapped I/O page diverts stores away from RAM. A store to address 0xFF00 also emits a one-cycle trigger for an external DMA engine. ROM contents and peripherals are not part of the block; they hang off its select and offset outputs.

Top module: `memmap_decoder`

## Requirements
- R1: After reset both banking registers hold 0, so the effective configuration `cfg` reads 3'b111 and `preg_rdata` reads 0 at addresses 0 and 1.
- R2: A write to address 0 loads the direction register and a write to address 1 loads the port register. From the next cycle `cfg` equals the low 3 bits of (~direction | port). Reading address 0 or 1 returns that register on `preg_rdata`, and `tgt_sel` bit 11 is set. `cfg` changes on no other input.
- R3: Addresses 0x0002–0x9FFF and 0xC000–0xCFFF always select RAM (`tgt_sel` bit 0).
- R4: 0xA000–0xBFFF selects the first ROM (bit 1) only when cfg[1:0] is 2'b11, with `rom_off` = address[12:0]; otherwise it selects RAM.
- R5: 0xE000–0xFFFF selects the upper ROM (bit 3) whenever cfg[1] is 1, with `rom_off` = address[12:0]; otherwise it selects RAM.
- R6: 0xD000–0xDFFF selects RAM when cfg[1:0] is 0. It selects the glyph ROM (bit 2, `char_off` = address[11:0]) when cfg[1:0] is nonzero and cfg[2] is 0. It holds the I/O page when cfg[1:0] is nonzero and cfg[2] is 1. Offsets are 0 whenever their target is not selected.
- R7: In the I/O page the targets and their `io_idx` values are as follows. 0xD000–0xD3FF is video, bit 4, index = address[5:0]. 0xD400–0xD7FF is sound, bit 5, index = address[4:0]. 0xD800–0xDBFF is colour RAM, bit 6, index = address[9:0]. 0xDC00–0xDCFF is timer 1, bit 7, index = address[3:0]. 0xDD00–0xDDFF is timer 2, bit 8, index = address[3:0]. `io_idx` is 0 for any other target.
- R8: In the I/O page, 0xDF00–0xDF0F selects the DMA controller (bit 9, index = address[3:0]). The rest of 0xDE00–0xDFFF is open I/O (bit 10), and there `rd_mask` is 0.
- R9: For colour RAM `rd_mask` is 0x0F, and `cram_wdata` always carries write data bits [3:0]. For every target other than colour RAM and open I/O, `rd_mask` is 0xFF.
- R10: When `cpu_we` is high, `ram_we` is asserted for every target outside a mapped I/O page. This includes ROM-overlaid addresses and the banking registers. `io_we` is asserted only for the peripheral windows (bits 4–9). A write to open I/O raises neither.
- R11: A write to 0xFF00 raises `dma_trig` for exactly the following cycle. It still writes RAM as R10 requires.
- R12: Exactly one bit of `tgt_sel` is set at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Processor address |
| cpu_we | input | 1 | Write strobe for the current address |
| cpu_wdata | input | 8 | Write data |
| tgt_sel | output | 12 | One-hot target select (bit map in R3–R8, R2) |
| rom_off | output | 13 | Offset into first or upper ROM |
| char_off | output | 12 | Offset into glyph ROM |
| io_idx | output | 10 | Masked peripheral register index |
| ram_we | output | 1 | Write enable to main RAM |
| io_we | output | 1 | Write enable to the selected peripheral |
| cram_wdata | output | 4 | Nibble written to colour RAM |
| rd_mask | output | 8 | Bits of read data driven by the target |
| preg_rdata | output | 8 | Banking register read value |
| cfg | output | 3 | Effective banking configuration |
| dma_trig | output | 1 | One-cycle DMA trigger |

## Verification
The hardest state to reach is one where the effective configuration differs from the port value. This happens only when some direction bits are 0, and those bits then force configuration bits high whatever the port holds. The stimulus first sets every direction bit to 1 and steps the port through all eight values, sweeping window edges under each. It then programs mixed direction and port pairs, and ends with random traffic. That traffic includes writes to addresses 0 and 1 between accesses, so the decode is checked on the first cycle after every bank change.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

   typedef enum logic [3:0] {
      RG_RAM    = 4'd0,
      RG_BASIC  = 4'd1,
      RG_CHAR   = 4'd2,
      RG_KERNAL = 4'd3,
      RG_VID    = 4'd4,
      RG_SND    = 4'd5,
      RG_CRAM   = 4'd6,
      RG_TIO1   = 4'd7,
      RG_TIO2   = 4'd8,
      RG_DMA    = 4'd9,
      RG_OPEN   = 4'd10,
      RG_PREG   = 4'd11
   } region_e;

   localparam int NUM_RG = 12;
   localparam int CFG_W  = 3;

endpackage

// File: rtl/memmap_cfg_regs.sv
module memmap_cfg_regs
   import memmap_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              hit_dir,
   input  logic              hit_port,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] dir_q,
   output logic [DATA_W-1:0] port_q,
   output logic [CFG_W-1:0]  cfg
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q  <= '0;
         port_q <= '0;
      end else if (we) begin
         if (hit_dir)  dir_q  <= wdata;
         if (hit_port) port_q <= wdata;
      end
   end

   logic [DATA_W-1:0] eff;
   assign eff = ~dir_q | port_q;
   assign cfg = eff[CFG_W-1:0];

   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && (hit_dir || hit_port)) |=> $stable(cfg)) else $error("cfg moved"); // R2

endmodule

// File: rtl/memmap_region_dec.sv
module memmap_region_dec
   import memmap_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [CFG_W-1:0]  cfg,
   output region_e           rg_base,
   output logic              io_page
);

   logic [3:0] blk;
   logic       low_lines_on;
   assign blk          = addr[ADDR_W-1 -: 4];
   assign low_lines_on = |cfg[1:0];

   always_comb begin
      rg_base = RG_RAM;
      io_page = 1'b0;
      unique case (blk)
         4'hA, 4'hB: if (cfg[1:0] == 2'b11) rg_base = RG_BASIC;
         4'hD: begin
            if (low_lines_on) begin
               if (cfg[2]) io_page = 1'b1;
               else        rg_base = RG_CHAR;
            end
         end
         4'hE, 4'hF: if (cfg[1]) rg_base = RG_KERNAL;
         default: rg_base = RG_RAM;
      endcase
      if (addr[ADDR_W-1:1] == '0) rg_base = RG_PREG;
   end

endmodule

// File: rtl/memmap_io_dec.sv
module memmap_io_dec
   import memmap_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int IDX_W     = 10,
   parameter int VID_IDX_W = 6,
   parameter int SND_IDX_W = 5,
   parameter int CRM_IDX_W = 10,
   parameter int TIO_IDX_W = 4,
   parameter int DMA_IDX_W = 4
) (
   input  logic [ADDR_W-1:0] addr,
   output region_e           io_rg,
   output logic [IDX_W-1:0]  io_idx
);

   localparam logic [IDX_W-1:0] VID_M = IDX_W'((1 << VID_IDX_W) - 1);
   localparam logic [IDX_W-1:0] SND_M = IDX_W'((1 << SND_IDX_W) - 1);
   localparam logic [IDX_W-1:0] CRM_M = IDX_W'((1 << CRM_IDX_W) - 1);
   localparam logic [IDX_W-1:0] TIO_M = IDX_W'((1 << TIO_IDX_W) - 1);
   localparam logic [IDX_W-1:0] DMA_M = IDX_W'((1 << DMA_IDX_W) - 1);

   logic [3:0]       page;
   logic [3:0]       row;
   logic [IDX_W-1:0] a_lo;
   assign page = addr[11:8];
   assign row  = addr[7:4];
   assign a_lo = addr[IDX_W-1:0];

   always_comb begin
      io_rg  = RG_OPEN;
      io_idx = '0;
      unique case (page)
         4'h0, 4'h1, 4'h2, 4'h3: begin io_rg = RG_VID;  io_idx = a_lo & VID_M; end
         4'h4, 4'h5, 4'h6, 4'h7: begin io_rg = RG_SND;  io_idx = a_lo & SND_M; end
         4'h8, 4'h9, 4'hA, 4'hB: begin io_rg = RG_CRAM; io_idx = a_lo & CRM_M; end
         4'hC:                   begin io_rg = RG_TIO1; io_idx = a_lo & TIO_M; end
         4'hD:                   begin io_rg = RG_TIO2; io_idx = a_lo & TIO_M; end
         4'hF: if (row == 4'h0)  begin io_rg = RG_DMA;  io_idx = a_lo & DMA_M; end
         default:                begin io_rg = RG_OPEN; io_idx = '0; end
      endcase
   end

endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
   import memmap_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int IDX_W     = 10,
   parameter int VID_IDX_W = 6,
   parameter int SND_IDX_W = 5,
   parameter int CRM_IDX_W = 10,
   parameter int TIO_IDX_W = 4,
   parameter int DMA_IDX_W = 4,
   parameter int ROM_OFF_W = 13,
   parameter int CHR_OFF_W = 12,
   parameter bit TRIG_REG  = 1'b1,
   parameter logic [15:0] TRIG_ADDR = 16'hFF00
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    cpu_addr,
   input  logic                 cpu_we,
   input  logic [DATA_W-1:0]    cpu_wdata,
   output logic [NUM_RG-1:0]    tgt_sel,
   output logic [ROM_OFF_W-1:0] rom_off,
   output logic [CHR_OFF_W-1:0] char_off,
   output logic [IDX_W-1:0]     io_idx,
   output logic                 ram_we,
   output logic                 io_we,
   output logic [3:0]           cram_wdata,
   output logic [DATA_W-1:0]    rd_mask,
   output logic [DATA_W-1:0]    preg_rdata,
   output logic [CFG_W-1:0]     cfg,
   output logic                 dma_trig
);

   localparam logic [DATA_W-1:0] MASK_ALL = '1;
   localparam logic [DATA_W-1:0] MASK_NIB = DATA_W'(4'hF);

   initial begin : p_param_chk
      assert (ADDR_W == 16) else $error("map is defined over 16 address bits");
      assert (DATA_W >= 4) else $error("data must hold a colour nibble");
      assert (VID_IDX_W <= 10 && SND_IDX_W <= 10 && CRM_IDX_W <= 10)
         else $error("window index wider than its 1 KiB window");
      assert (TIO_IDX_W <= 8 && DMA_IDX_W <= 4) else $error("small window index too wide");
      assert (IDX_W >= VID_IDX_W && IDX_W >= SND_IDX_W && IDX_W >= CRM_IDX_W &&
              IDX_W >= TIO_IDX_W && IDX_W >= DMA_IDX_W && IDX_W <= 12)
         else $error("IDX_W must cover every window index");
      assert (ROM_OFF_W == 13 && CHR_OFF_W == 12) else $error("ROM window sizes are fixed");
   end

   logic hit_dir, hit_port;
   assign hit_dir  = (cpu_addr == ADDR_W'(0));
   assign hit_port = (cpu_addr == ADDR_W'(1));

   logic [DATA_W-1:0] dir_q, port_q;

   memmap_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cpu_we), .hit_dir(hit_dir), .hit_port(hit_port),
      .wdata(cpu_wdata), .dir_q(dir_q), .port_q(port_q), .cfg(cfg)
   );

   region_e rg_base, io_rg, rg;
   logic    io_page;
   logic [IDX_W-1:0] io_idx_raw;

   memmap_region_dec #(.ADDR_W(ADDR_W)) u_region (
      .addr(cpu_addr), .cfg(cfg), .rg_base(rg_base), .io_page(io_page)
   );

   memmap_io_dec #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .VID_IDX_W(VID_IDX_W), .SND_IDX_W(SND_IDX_W),
      .CRM_IDX_W(CRM_IDX_W), .TIO_IDX_W(TIO_IDX_W), .DMA_IDX_W(DMA_IDX_W)
   ) u_io (
      .addr(cpu_addr), .io_rg(io_rg), .io_idx(io_idx_raw)
   );

   assign rg = io_page ? io_rg : rg_base;

   for (genvar gi = 0; gi < NUM_RG; gi++) begin : g_sel
      assign tgt_sel[gi] = (rg == region_e'(gi));
   end

   assign io_idx   = io_page ? io_idx_raw : '0;
   assign rom_off  = (rg == RG_BASIC || rg == RG_KERNAL) ? cpu_addr[ROM_OFF_W-1:0] : '0;
   assign char_off = (rg == RG_CHAR) ? cpu_addr[CHR_OFF_W-1:0] : '0;

   assign ram_we     = cpu_we && !io_page;
   assign io_we      = cpu_we && io_page && (io_rg != RG_OPEN);
   assign cram_wdata = cpu_wdata[3:0];

   always_comb begin
      unique case (rg)
         RG_CRAM: rd_mask = MASK_NIB;
         RG_OPEN: rd_mask = '0;
         default: rd_mask = MASK_ALL;
      endcase
   end

   assign preg_rdata = hit_dir ? dir_q : (hit_port ? port_q : '0);

   logic trig_hit;
   assign trig_hit = cpu_we && (cpu_addr == TRIG_ADDR);

   if (TRIG_REG) begin : g_trig_reg
      logic trig_q;
      always_ff @(posedge clk) begin
         if (!rst_n) trig_q <= 1'b0;
         else        trig_q <= trig_hit;
      end
      assign dma_trig = trig_q;

      AST_TRIG_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
         dma_trig |-> ($past(cpu_we) && $past(cpu_addr) == TRIG_ADDR)) else $error("stray trigger"); // R11
   end else begin : g_trig_comb
      assign dma_trig = trig_hit;
   end

   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(tgt_sel) == 1) else $error("target not one-hot"); // R12

   AST_ROM_WR_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_we && (tgt_sel[RG_BASIC] || tgt_sel[RG_CHAR] || tgt_sel[RG_KERNAL])) |-> (ram_we && !io_we))
      else $error("ROM write lost"); // R10

   AST_IO_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      io_we |-> !ram_we) else $error("double write"); // R10

   AST_BASIC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_sel[RG_BASIC] |-> (cfg[1:0] == 2'b11)) else $error("first ROM wrongly mapped"); // R4

   AST_KERNAL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_sel[RG_KERNAL] |-> cfg[1]) else $error("upper ROM wrongly mapped"); // R5

   AST_CRAM_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_sel[RG_CRAM] |-> (rd_mask == MASK_NIB)) else $error("colour mask"); // R9

endmodule

// File: tb/memmap_decoder_tb_top.sv
`timescale 1ns/1ps
module memmap_decoder_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic        cpu_we = 1'b0;
   logic [7:0]  cpu_wdata = '0;
   logic [11:0] tgt_sel;
   logic [12:0] rom_off;
   logic [11:0] char_off;
   logic [9:0]  io_idx;
   logic        ram_we, io_we, dma_trig;
   logic [3:0]  cram_wdata;
   logic [7:0]  rd_mask, preg_rdata;
   logic [2:0]  cfg;

   always #2.5 clk = ~clk;

   memmap_decoder dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
      .tgt_sel(tgt_sel), .rom_off(rom_off), .char_off(char_off), .io_idx(io_idx),
      .ram_we(ram_we), .io_we(io_we), .cram_wdata(cram_wdata), .rd_mask(rd_mask),
      .preg_rdata(preg_rdata), .cfg(cfg), .dma_trig(dma_trig)
   );

   int errors = 0;
   int checks = 0;
   int m_dir = 0;
   int m_port = 0;
   bit exp_trig = 1'b0;

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h addr=%04h", req, what, act, exp, cpu_addr);
      end
   endtask

   // behavioural reference: target number and the requirement it belongs to
   task automatic ref_dec(input int a, input int c, output int t, output string tag);
      if (a < 2) begin t = 11; tag = "R2"; end
      else if (a < 'hA000) begin t = 0; tag = "R3"; end
      else if (a < 'hC000) begin t = ((c & 3) == 3) ? 1 : 0; tag = "R4"; end
      else if (a < 'hD000) begin t = 0; tag = "R3"; end
      else if (a < 'hE000) begin
         tag = "R6";
         if ((c & 3) == 0) t = 0;
         else if ((c & 4) == 0) t = 2;
         else begin
            tag = "R7";
            if (a < 'hD400) t = 4;
            else if (a < 'hD800) t = 5;
            else if (a < 'hDC00) t = 6;
            else if (a < 'hDD00) t = 7;
            else if (a < 'hDE00) t = 8;
            else begin
               tag = "R8";
               t = (a >= 'hDF00 && a <= 'hDF0F) ? 9 : 10;
            end
         end
      end else begin t = ((c & 2) != 0) ? 3 : 0; tag = "R5"; end
   endtask

   task automatic step(input logic [15:0] a, input logic we, input logic [7:0] d);
      int t, c, e_idx, e_mask;
      string tag;
      @(negedge clk);
      cpu_addr = a; cpu_we = we; cpu_wdata = d;
      #1;
      c = (~m_dir | m_port) & 7;
      ref_dec(int'(a), c, t, tag);
      case (t)
         4: e_idx = a & 63;
         5: e_idx = a & 31;
         6: e_idx = a & 1023;
         7, 8, 9: e_idx = a & 15;
         default: e_idx = 0;
      endcase
      e_mask = (t == 6) ? 'h0F : ((t == 10) ? 0 : 'hFF);
      chk(tag,   "tgt_sel",  32'(tgt_sel), 32'(1 << t));
      chk("R12", "onehot",   32'($countones(tgt_sel)), 32'd1);
      chk("R2",  "cfg",      32'(cfg), 32'(c));
      chk((t == 3) ? "R5" : "R4", "rom_off", 32'(rom_off), (t == 1 || t == 3) ? 32'(a & 16'h1FFF) : 32'd0);
      chk("R6",  "char_off", 32'(char_off), (t == 2) ? 32'(a & 16'h0FFF) : 32'd0);
      chk("R7",  "io_idx",   32'(io_idx), 32'(e_idx));
      chk("R9",  "rd_mask",  32'(rd_mask), 32'(e_mask));
      chk("R9",  "cram_wdata", 32'(cram_wdata), 32'(d & 8'h0F));
      chk("R10", "ram_we",   32'(ram_we), 32'(we && !(t >= 4 && t <= 10)));
      chk("R10", "io_we",    32'(io_we), 32'(we && t >= 4 && t <= 9));
      chk("R2",  "preg_rdata", 32'(preg_rdata), (a == 0) ? 32'(m_dir) : ((a == 1) ? 32'(m_port) : 32'd0));
      chk("R11", "dma_trig", 32'(dma_trig), 32'(exp_trig));
      @(posedge clk);
      if (we && a == 16'h0000) m_dir = int'(d);
      if (we && a == 16'h0001) m_port = int'(d);
      exp_trig = we && (a == 16'hFF00);
   endtask

   logic [15:0] probe [26] = '{16'h0002, 16'h1234, 16'h9FFF, 16'hA000, 16'hBFFF, 16'hC000,
      16'hCFFF, 16'hD000, 16'hD03F, 16'hD3FF, 16'hD400, 16'hD7FF, 16'hD800, 16'hDBFF,
      16'hDC0F, 16'hDCFF, 16'hDD05, 16'hDDFF, 16'hDE00, 16'hDF00, 16'hDF0F, 16'hDF10,
      16'hDFFF, 16'hE000, 16'hFF00, 16'hFFFF};

   initial begin : watchdog
      #(100000 * 5);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      repeat (4) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      cpu_addr = 16'h0000; #1;
      chk("R1", "reset cfg", 32'(cfg), 32'd7);
      chk("R1", "reset dir", 32'(preg_rdata), 32'd0);
      cpu_addr = 16'h0001; #1;
      chk("R1", "reset port", 32'(preg_rdata), 32'd0);
      chk("R1", "reset tgt", 32'(tgt_sel), 32'h800);

      // R3 R4 R5 R6 R7 R8: all eight configs with full direction
      step(16'h0000, 1'b1, 8'hFF);
      for (int k = 0; k < 8; k++) begin
         step(16'h0001, 1'b1, 8'(k));
         for (int i = 0; i < 26; i++) begin
            step(probe[i], 1'b0, 8'h00);
            step(probe[i], 1'b1, 8'($urandom));
         end
         step(16'h0000, 1'b0, 8'h00);
         step(16'h0001, 1'b0, 8'h00);
      end

      // R2: cleared direction bits force config bits high
      step(16'h0000, 1'b1, 8'h05);
      step(16'h0001, 1'b1, 8'h02);
      for (int i = 0; i < 26; i++) step(probe[i], 1'b1, 8'hA5);
      step(16'h0000, 1'b1, 8'h00);
      for (int i = 0; i < 26; i++) step(probe[i], 1'b0, 8'h00);

      // R11: back-to-back trigger writes then a gap
      step(16'hFF00, 1'b1, 8'h11);
      step(16'hFF00, 1'b1, 8'h22);
      step(16'hFF01, 1'b1, 8'h33);
      step(16'hFF00, 1'b0, 8'h00);
      step(16'h1000, 1'b0, 8'h00);

      // random traffic, bank changes mixed in
      for (int n = 0; n < 2500; n++) begin
         logic [15:0] ra;
         int sel;
         sel = int'($urandom_range(0, 9));
         if (sel == 0) ra = 16'($urandom_range(0, 1));
         else if (sel < 5) ra = 16'hD000 | 16'($urandom_range(0, 16'h0FFF));
         else ra = 16'($urandom);
         step(ra, 1'($urandom), 8'($urandom));
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule